// File: doc/BRIEF.md
# Interframe Gap Timer with Mode Strap

This block times the quiet interval that must pass between frames on one half-duplex 10 Mb/s port. It runs from an 80 MHz clock, watches the port's transmit enable and carrier sense, and raises a gap-complete output once the line has been quiet for a programmable number of clocks. The transmit side uses that output to decide when the next frame may start.

A strap input is captured during reset and selects where the quiet interval begins. In compatible mode the interval starts only once both transmit and carrier activity have stopped. In fast mode the interval starts as soon as transmit enable drops. Carrier that the transceiver echoes back from the port's own transmission is ignored until it ends, so a looped-back transceiver does not add to the gap and the port can send back to back at full wire speed. Carrier that starts after the echo has ended is treated as genuine receive activity.

Top module: `ifg_timer`

## Requirements
- R1: The mode is taken from `mode_strap` on each clock edge while `rst_n` is low and is held from the first edge with `rst_n` high until the next reset. Strap high (1) selects compatible mode and strap low (0) selects fast mode. Later strap changes have no effect.
- R2: After a reset clock edge, `gap_done` is 0.
- R3: A `gap_len` of 0 selects the parameter `DEFAULT_GAP` as the gap length. Any other value is the gap length in clocks.
- R4: `gap_done` goes to 1 at the clock edge that completes N consecutive quiet edges, where N is the gap length. An edge is quiet when `tx_en` is 0 and unmasked carrier is 0.
- R5: In compatible mode, every edge with `crs` at 1 counts as activity. The gap therefore starts only after both `tx_en` and `crs` are 0.
- R6: In compatible mode, carrier that returns before `gap_done` is set clears the count. A full N quiet edges are then needed after that carrier ends.
- R7: In fast mode, the count starts at the first edge with `tx_en` at 0. Carrier that has been high without a break since `tx_en` was last 1 is ignored, so `gap_done` can rise while that carrier is still asserted.
- R8: In fast mode, once carrier has been sampled at 0 after transmission, a new rise of `crs` counts as receive activity and clears the count.
- R9: Once set, `gap_done` stays at 1 whatever `crs` does until an edge with `tx_en` at 1. That edge clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 80 MHz timing clock |
| rst_n | input | 1 | Synchronous reset, active low; the mode strap is captured while low |
| mode_strap | input | 1 | 1 = compatible start of gap, 0 = fast start of gap |
| tx_en | input | 1 | Transmit enable of the port |
| crs | input | 1 | Carrier sense of the port |
| gap_len | input | GAP_W | Gap length in clocks; 0 selects DEFAULT_GAP |
| gap_done | output | 1 | Gap complete; the next transmission may start |

## Verification
The bench builds the timer with GAP_W = 8 and DEFAULT_GAP = 24 rather than the 12-bit, 768-clock defaults. This keeps the default-length path (R3) within a few dozen cycles, and random gap lengths of 1 to 8 close many gaps in each random run. Because the lengths are short, echoed carrier can outlast the whole gap in fast mode. Carrier can also return in the last cycles of a gap in compatible mode. Both modes are run after separate resets so that the strap capture is exercised in each direction.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  typedef enum logic {
    MODE_FAST   = 1'b0,
    MODE_COMPAT = 1'b1
  } ifg_mode_e;

  // Effective gap length: a zero request falls back to the default.
  function automatic int unsigned gap_target(input int unsigned req,
                                             input int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

  // True when one more quiet clock completes the gap.
  function automatic logic gap_reached(input int unsigned quiet_cnt,
                                       input int unsigned target);
    return (quiet_cnt + 1) >= target;
  endfunction

  // Next state of the echo mask: armed during transmit, kept while the
  // carrier stays up without a break, always clear in compatible mode.
  function automatic logic echo_mask_next(input logic fast,
                                          input logic tx,
                                          input logic mask,
                                          input logic carrier);
    return fast & (tx | (mask & carrier));
  endfunction

endpackage

// File: rtl/ifg_mode_latch.sv
module ifg_mode_latch
  import ifg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strap,
  output ifg_mode_e mode
);

  ifg_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ifg_mode_e'(strap);
    end
  end

  assign mode = mode_q;

  // R1: mode frozen once reset is released
  p_mode_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q))
    else $error("mode changed outside reset");

endmodule

// File: rtl/ifg_echo_filter.sv
module ifg_echo_filter
  import ifg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic tx_en,
  input  logic crs,
  output logic echo_mask,
  output logic crs_eff
);

  logic mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else begin
      mask_q <= echo_mask_next(fast_mode, tx_en, mask_q, crs);
    end
  end

  assign echo_mask = mask_q;
  assign crs_eff   = crs & ~mask_q;

  // R5: compatible mode never hides carrier
  p_no_mask_compat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_mode |=> !mask_q)
    else $error("echo mask set in compatible mode");

  // R8: a carrier gap after transmit ends the echo window
  p_mask_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !crs) |=> !mask_q)
    else $error("echo mask survived a carrier gap");

  // R7: transmit arms the mask in fast mode
  p_mask_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_mode && tx_en) |=> mask_q)
    else $error("echo mask not armed by transmit");

endmodule

// File: rtl/ifg_gap_count.sv
module ifg_gap_count
  import ifg_pkg::*;
#(
  parameter int unsigned GAP_W       = 12,
  parameter int unsigned DEFAULT_GAP = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             line_busy,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_done
);

  localparam int unsigned CNT_W = GAP_W;

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  int unsigned      target;
  logic             last_quiet;

  assign target     = gap_target(32'(gap_len), DEFAULT_GAP);
  assign last_quiet = gap_reached(32'(cnt_q), target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tx_en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (line_busy) begin
        cnt_q <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        done_q <= last_quiet;
      end
    end
  end

  assign gap_done = done_q;

  // R9: transmit clears the gap flag
  p_tx_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> !done_q)
    else $error("gap flag survived transmit");

  // R9: flag holds until transmit
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !tx_en) |=> done_q)
    else $error("gap flag dropped without transmit");

  // R5: activity before completion blocks the flag
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && line_busy) |=> !done_q)
    else $error("gap completed during activity");

  // R4: the flag rises only after a quiet edge
  p_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(!line_busy) && $past(!tx_en)))
    else $error("gap flag rose after an active edge");

endmodule

// File: rtl/ifg_timer.sv
module ifg_timer
  import ifg_pkg::*;
#(
  parameter int unsigned GAP_W       = 12,
  parameter int unsigned DEFAULT_GAP = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic             tx_en,
  input  logic             crs,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_done
);

  ifg_mode_e mode;
  logic      fast_mode;
  logic      echo_mask;
  logic      crs_eff;
  logic      line_busy;

  ifg_mode_latch u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (mode_strap),
    .mode  (mode)
  );

  assign fast_mode = (mode == MODE_FAST);

  ifg_echo_filter u_echo (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_mode (fast_mode),
    .tx_en     (tx_en),
    .crs       (crs),
    .echo_mask (echo_mask),
    .crs_eff   (crs_eff)
  );

  assign line_busy = tx_en | crs_eff;

  ifg_gap_count #(
    .GAP_W       (GAP_W),
    .DEFAULT_GAP (DEFAULT_GAP)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .line_busy (line_busy),
    .gap_len   (gap_len),
    .gap_done  (gap_done)
  );

  // R6: in compatible mode raw carrier before completion blocks the flag
  p_compat_crs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && crs && !gap_done) |=> !gap_done)
    else $error("carrier ignored in compatible mode");

endmodule

// File: tb/sim_ifg_timer.sv
module sim_ifg_timer;

  localparam int GW   = 8;
  localparam int DEFG = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_strap = 1'b1;
  logic          tx_en = 1'b0;
  logic          crs = 1'b0;
  logic [GW-1:0] gap_len = 8'd5;
  logic          gap_done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ifg_timer #(.GAP_W(GW), .DEFAULT_GAP(DEFG)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_strap (mode_strap),
    .tx_en      (tx_en),
    .crs        (crs),
    .gap_len    (gap_len),
    .gap_done   (gap_done)
  );

  // Reference model written from the requirements.
  bit m_fast, m_hide, m_done;
  int m_quiet;

  function automatic int want_len(input int req);
    if (req == 0) return DEFG;
    return req;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fast  = !mode_strap;
      m_hide  = 0;
      m_done  = 0;
      m_quiet = 0;
    end else begin
      bit real_crs;
      real_crs = crs && !m_hide;
      if (tx_en) begin
        m_quiet = 0;
        m_done  = 0;
      end else if (!m_done) begin
        if (real_crs) m_quiet = 0;
        else begin
          m_quiet++;
          if (m_quiet >= want_len(int'(gap_len))) m_done = 1;
        end
      end
      m_hide = m_fast && (tx_en || (m_hide && crs));
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gap_done=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic t, input logic c);
    tx_en = t;
    crs   = c;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 0; mode_strap = s; tx_en = 0; crs = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset", gap_done, 1'b0);
    rst_n = 1;
  endtask

  task automatic quiet_run(input string tag, input int n);
    for (int i = 0; i < n - 1; i++) tick(0, 0);
    chk(tag, gap_done, 1'b0);
    tick(0, 0);
    chk(tag, gap_done, 1'b1);
  endtask

  task automatic random_run(input logic s, input int n);
    do_reset(s);
    for (int i = 0; i < n; i++) begin
      logic t, c;
      if (i % 40 == 0) gap_len = GW'($urandom % 9);
      t = tx_en;
      c = crs;
      if ($urandom % 14 == 0) t = ~t;
      if (t) c = ($urandom % 8 != 0);
      else if ($urandom % 10 == 0) c = ~c;
      tick(t, c);
      chk("R4 model", gap_done, m_done);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // compatible mode
    gap_len = 8'd5;
    do_reset(1'b1);
    tick(1, 0); tick(1, 0);
    chk("R9 tx", gap_done, 1'b0);
    // R5: carrier after transmit holds the count
    tick(0, 1); tick(0, 1); tick(0, 1);
    chk("R5 crs", gap_done, 1'b0);
    quiet_run("R5 R4 gap", 5);
    // R9: carrier after completion has no effect
    tick(0, 1); chk("R9 hold", gap_done, 1'b1);
    tick(0, 1); tick(0, 1); chk("R9 hold", gap_done, 1'b1);
    tick(1, 0); chk("R9 clear", gap_done, 1'b0);
    // R6: carrier returning mid-gap restarts count
    tick(0, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    quiet_run("R6 restart", 5);
    // R1: strap change after reset keeps compatible behaviour
    mode_strap = 1'b0;
    tick(1, 1); tick(1, 1);
    tick(0, 1); tick(0, 1); tick(0, 1);
    quiet_run("R1 strap held", 5);
    // R3: zero length selects default
    gap_len = 8'd0;
    tick(1, 0);
    quiet_run("R3 default", DEFG);
    // fast mode
    gap_len = 8'd5;
    mode_strap = 1'b1;
    do_reset(1'b0);
    mode_strap = 1'b1;
    // R7: echoed carrier ignored
    tick(1, 1); tick(1, 1); tick(1, 1);
    tick(0, 1); tick(0, 1); tick(0, 1); tick(0, 0);
    chk("R7 echo", gap_done, 1'b0);
    tick(0, 0);
    chk("R7 echo", gap_done, 1'b1);
    tick(1, 1);
    for (int i = 0; i < 4; i++) tick(0, 1);
    chk("R7 long echo", gap_done, 1'b0);
    tick(0, 1);
    chk("R7 long echo", gap_done, 1'b1);
    // R8: fresh carrier after echo ended restarts gap
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1);
    chk("R8 rx", gap_done, 1'b0);
    quiet_run("R8 restart", 5);
    // random phases in both modes
    random_run(1'b1, 4000);
    random_run(1'b0, 4000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule